// File: doc/BRIEF.md
# Wake-Up Request Controller with Programmable Debounce

This block sits in the always-on domain of a low-power system and decides when the core supply must be woken. It runs on the slow clock and watches four kinds of source. The first is an active-low force-wake pin. The second and third are a brownout alarm and a real-time-clock alarm. The fourth is a group of general wake-up inputs, each enabled on its own. Each source is gated by its own enable field in a read-write configuration register.

The force-wake pin and the general inputs each pass through a debouncer. A debouncer counts consecutive slow-clock cycles of activity and qualifies the input once a threshold is reached. The threshold is chosen by a code. Every asynchronous input first passes through a two-flop synchronizer.

A small state machine turns the merged request into a single one-cycle wake pulse. It also records the sources that were active at that moment in a sticky cause register. The cause register is cleared by a write-one-to-clear strobe.

The state machine has three states:
- IDLE waits for a request. IDLE→FIRE when any enabled, qualified source is active. The active sources are captured into the cause register on this transition.
- FIRE drives the pulse for one cycle. FIRE→HOLD when the request is still present. FIRE→IDLE when it has gone.
- HOLD waits for the request to drop. HOLD→IDLE when no source is active.

Top module: `wkup_ctrl`

## Requirements
- R1: The force-wake pin `force_n` is active low. It can cause a wake only when config bit 0 is 1. With the bit at 0, a low pin produces no pulse and sets no cause bit.
- R2: The brownout alarm `bod_alarm` (active high, not debounced) causes a wake only when config bit 1 is 1. Its pulse appears on the 3rd rising clock edge after the alarm is first presented.
- R3: The RTC alarm `rtc_alarm` (active high, not debounced) causes a wake only when config bit 2 is 1. It has the same 3-edge latency as R2.
- R4: The force-wake debounce code is config bits [5:3]. Code 0 means immediate detection: one active sample on a slow-clock edge qualifies. The pulse appears on the 4th rising edge after the pin goes low.
- R5: Force-wake codes 1, 2, 3, 4 and 5 need T = 3, 32, 512, 4096 and 32768 consecutive low samples. The pulse appears on rising edge 3+T after the pin goes low.
- R6: A debouncer restarts its count from zero whenever its input is sampled inactive before the threshold is reached. A low run shorter than T therefore produces no pulse, whereas a run of exactly T does.
- R7: Reserved debounce codes never qualify and never cause a wake. These are force-wake codes 6 and 7 and input code 3.
- R8: The general inputs `wk_in` are active high, and config bits [8+N-1:8] enable them one per input. Input code (config bits [7:6]) 0, 1 and 2 gives T = 1, 3 and 32 for the OR of the enabled inputs. The pulse appears on edge 3+T. Activity on a disabled input is ignored.
- R9: `wake_pulse` lasts exactly one cycle per request. No further pulse occurs until every enabled source has dropped.
- R10: On each pulse, `stat_cause` records the active sources in its bits: bit0 force, bit1 brownout, bit2 RTC, bit3 general inputs. The bits stay set until cleared by `stat_clr_we` with a 1 in the matching `stat_clr_mask` bit.
- R11: After reset, the config register reads 0 (all sources off, immediate detection), the cause register is 0, and no pulse is driven. A config write is read back on `cfg_rdata` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8+N_WK | Configuration write data |
| cfg_rdata | output | 8+N_WK | Configuration register contents |
| stat_clr_we | input | 1 | Cause clear strobe |
| stat_clr_mask | input | 4 | Cause bits to clear (write one to clear) |
| stat_cause | output | 4 | Sticky wake cause |
| force_n | input | 1 | Force-wake pin, active low, asynchronous |
| bod_alarm | input | 1 | Brownout alarm, asynchronous |
| rtc_alarm | input | 1 | RTC alarm, asynchronous |
| wk_in | input | N_WK | General wake-up inputs, asynchronous |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
The hardest situation to reach from the ports is a debouncer sitting one count short of its threshold when its input drops out. The pin must be held low for a run of cycles of exactly chosen length, counted through the synchronizer.

The stimulus drives the pin on falling edges with code 1 selected. It applies runs of two low cycles separated by one high cycle and checks that no pulse follows. It then applies a run of exactly three low cycles and checks that one pulse follows. The longest thresholds are measured end to end against the 3+T latency, which exposes off-by-one errors in the counter compare.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    localparam int CAUSE_W = 4;
    localparam int THR_W   = 17;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } wk_state_e;

    // Threshold in consecutive active samples; 0 marks a reserved code.
    function automatic logic [THR_W-1:0] dbnc_thresh(input bit is_input, input logic [2:0] code);
        logic [THR_W-1:0] t;
        t = '0;
        if (!is_input) begin
            unique case (code)
                3'd0: t = 17'd1;
                3'd1: t = 17'd3;
                3'd2: t = 17'd32;
                3'd3: t = 17'd512;
                3'd4: t = 17'd4096;
                3'd5: t = 17'd32768;
                default: t = '0;
            endcase
        end else begin
            unique case (code)
                3'd0: t = 17'd1;
                3'd1: t = 17'd3;
                3'd2: t = 17'd32;
                default: t = '0;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int          WIDTH   = 1,
    parameter logic [0:0]  RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {WIDTH{RST_VAL}};
            stage2 <= {WIDTH{RST_VAL}};
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/wkup_debounce.sv
module wkup_debounce
    import wkup_pkg::*;
#(
    parameter bit IS_INPUT = 1'b0,
    parameter int CODE_W   = 3,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [CODE_W-1:0] code,
    output logic              qualified
);
    localparam int EXT_W = CNT_W + 1;

    logic [THR_W-1:0] thresh;
    logic             reserved;
    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] next_cnt;
    logic             qual_q;

    always_comb begin
        logic [2:0] code3;
        code3    = 3'(code);
        thresh   = dbnc_thresh(IS_INPUT, code3);
        reserved = (thresh == '0);
        next_cnt = EXT_W'(cnt_q) + EXT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (!active || reserved) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (THR_W'(next_cnt) >= thresh) begin
            qual_q <= 1'b1;
        end else begin
            cnt_q  <= CNT_W'(next_cnt);
        end
    end

    assign qualified = qual_q;

    // R6: qualification needs the input active on the previous edge
    a_r6_qual_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q |-> $past(active));

    // R7: a reserved code held across an edge never qualifies
    a_r7_reserved_never: assert property (@(posedge clk) disable iff (!rst_n)
        (reserved && $past(reserved)) |-> !qual_q);
endmodule

// File: rtl/wkup_fsm.sv
module wkup_fsm
    import wkup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic capture,
    output logic fire
);
    wk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)  state_d = ST_FIRE;
            ST_FIRE: state_d = req ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture = (state_q == ST_IDLE) && req;
        fire    = (state_q == ST_FIRE);
    end

    // R9: the pulse never lasts two cycles
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R9: no new pulse while a request is held
    a_r9_no_repulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && req) |=> !fire);
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
    import wkup_pkg::*;
#(
    parameter int N_WK  = 4,
    parameter int CNT_W = 16,
    localparam int CFG_W = 8 + N_WK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               stat_clr_we,
    input  logic [CAUSE_W-1:0] stat_clr_mask,
    output logic [CAUSE_W-1:0] stat_cause,
    input  logic               force_n,
    input  logic               bod_alarm,
    input  logic               rtc_alarm,
    input  logic [N_WK-1:0]    wk_in,
    output logic               wake_pulse
);
    logic [CFG_W-1:0]   cfg_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               force_s;
    logic [1:0]         alarm_s;
    logic [N_WK-1:0]    wk_s;
    logic               force_qual;
    logic               wk_qual;
    logic [CAUSE_W-1:0] src;
    logic               req;
    logic               capture;
    logic               fire;

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end
    assign cfg_rdata = cfg_q;

    // synchronizers
    wkup_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_sync_force (
        .clk(clk), .rst_n(rst_n), .d_async(force_n), .q_sync(force_s));
    wkup_sync #(.WIDTH(2), .RST_VAL(1'b0)) u_sync_alarm (
        .clk(clk), .rst_n(rst_n), .d_async({rtc_alarm, bod_alarm}), .q_sync(alarm_s));
    wkup_sync #(.WIDTH(N_WK), .RST_VAL(1'b0)) u_sync_wk (
        .clk(clk), .rst_n(rst_n), .d_async(wk_in), .q_sync(wk_s));

    // debouncers
    wkup_debounce #(.IS_INPUT(1'b0), .CODE_W(3), .CNT_W(CNT_W)) u_dbnc_force (
        .clk(clk), .rst_n(rst_n), .active(!force_s),
        .code(cfg_q[5:3]), .qualified(force_qual));
    wkup_debounce #(.IS_INPUT(1'b1), .CODE_W(2), .CNT_W(CNT_W)) u_dbnc_wk (
        .clk(clk), .rst_n(rst_n), .active(|(wk_s & cfg_q[CFG_W-1:8])),
        .code(cfg_q[7:6]), .qualified(wk_qual));

    // source combining
    always_comb begin
        src[0] = cfg_q[0] && force_qual;
        src[1] = cfg_q[1] && alarm_s[0];
        src[2] = cfg_q[2] && alarm_s[1];
        src[3] = wk_qual;
        req    = |src;
    end

    wkup_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .capture(capture), .fire(fire));

    // sticky cause register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & ~(stat_clr_we ? stat_clr_mask : '0))
                     | (capture ? src : '0);
        end
    end

    assign stat_cause = cause_q;
    assign wake_pulse = fire;

    // R1: force cause only with its enable set
    a_r1_force_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_q[0]) |-> $past(cfg_q[0]));

    // R2: brownout cause only with its enable set
    a_r2_bod_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_q[1]) |-> $past(cfg_q[1]));

    // R3: RTC cause only with its enable set
    a_r3_rtc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_q[2]) |-> $past(cfg_q[2]));

    // R10: each pulse leaves a recorded cause
    a_r10_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (cause_q != '0));

    // R10: cleared bits are zero unless a capture coincided
    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_we && !capture) |=> ((cause_q & $past(stat_clr_mask)) == '0));
endmodule

// File: tb/wkup_ctrl_tb.sv
module wkup_ctrl_tb;
    localparam int N_WK  = 4;
    localparam int CFG_W = 8 + N_WK;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_rdata;
    logic             stat_clr_we = 1'b0;
    logic [3:0]       stat_clr_mask = '0;
    logic [3:0]       stat_cause;
    logic             force_n = 1'b1;
    logic             bod_alarm = 1'b0;
    logic             rtc_alarm = 1'b0;
    logic [N_WK-1:0]  wk_in = '0;
    logic             wake_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    wkup_ctrl #(.N_WK(N_WK)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
        .stat_cause(stat_cause), .force_n(force_n), .bod_alarm(bod_alarm),
        .rtc_alarm(rtc_alarm), .wk_in(wk_in), .wake_pulse(wake_pulse));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic clear_cause();
        @(negedge clk); stat_clr_we = 1'b1; stat_clr_mask = 4'hF;
        @(negedge clk); stat_clr_we = 1'b0; stat_clr_mask = 4'h0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts rising edges from the current negedge until a pulse is seen.
    task automatic measure(input int limit, output int lat, output bit seen);
        seen = 1'b0; lat = 0;
        while (!seen && lat < limit) begin
            @(posedge clk); #1;
            lat++;
            if (wake_pulse) seen = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic count_pulses(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (wake_pulse) pulses++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle_cycles(3);
        check(cfg_rdata == '0, "R11 cfg reset", int'(cfg_rdata), 0);
        check(stat_cause == '0, "R11 cause reset", int'(stat_cause), 0);
        check(wake_pulse == 1'b0, "R11 pulse reset", int'(wake_pulse), 0);
        rst_n = 1'b1;
        idle_cycles(2);
        write_cfg(12'hA5C);
        check(cfg_rdata == 12'hA5C, "R11 cfg readback", int'(cfg_rdata), 'hA5C);
        write_cfg('0);
    endtask

    task automatic t_force(input int code, input int thr);
        int lat; bit seen;
        clear_cause();
        write_cfg(CFG_W'((code << 3) | 1));
        force_n = 1'b0;
        measure(thr + 20, lat, seen);
        check(seen && lat == thr + 3, (code == 0) ? "R4 force latency" : "R5 force latency",
              lat, thr + 3);
        check(stat_cause == 4'b0001, "R10 force cause", int'(stat_cause), 1);
        force_n = 1'b1;
        idle_cycles(5);
    endtask

    task automatic t_force_disabled();
        int p;
        clear_cause();
        write_cfg('0);
        force_n = 1'b0;
        count_pulses(20, p);
        check(p == 0, "R1 force disabled pulses", p, 0);
        check(stat_cause == 4'h0, "R1 force disabled cause", int'(stat_cause), 0);
        force_n = 1'b1;
        idle_cycles(5);
    endtask

    task automatic t_alarm(input bit rtc);
        int lat; bit seen; int p;
        clear_cause();
        write_cfg('0);
        if (rtc) rtc_alarm = 1'b1; else bod_alarm = 1'b1;
        count_pulses(15, p);
        check(p == 0, rtc ? "R3 rtc disabled" : "R2 bod disabled", p, 0);
        rtc_alarm = 1'b0; bod_alarm = 1'b0;
        idle_cycles(5);
        write_cfg(rtc ? CFG_W'(4) : CFG_W'(2));
        if (rtc) rtc_alarm = 1'b1; else bod_alarm = 1'b1;
        measure(20, lat, seen);
        check(seen && lat == 3, rtc ? "R3 rtc latency" : "R2 bod latency", lat, 3);
        check(stat_cause == (rtc ? 4'b0100 : 4'b0010), rtc ? "R3 rtc cause" : "R2 bod cause",
              int'(stat_cause), rtc ? 4 : 2);
        rtc_alarm = 1'b0; bod_alarm = 1'b0;
        idle_cycles(5);
    endtask

    task automatic t_restart();
        int p;
        clear_cause();
        write_cfg(CFG_W'((1 << 3) | 1));
        for (int k = 0; k < 4; k++) begin
            force_n = 1'b0; idle_cycles(2);
            force_n = 1'b1; idle_cycles(1);
        end
        count_pulses(10, p);
        check(p == 0, "R6 short runs no wake", p, 0);
        force_n = 1'b0; idle_cycles(3);
        force_n = 1'b1;
        count_pulses(10, p);
        check(p == 1, "R6 exact run wakes", p, 1);
        idle_cycles(3);
    endtask

    task automatic t_reserved();
        int p;
        clear_cause();
        write_cfg(CFG_W'((6 << 3) | 1));
        force_n = 1'b0;
        count_pulses(100, p);
        check(p == 0, "R7 force code 6", p, 0);
        write_cfg(CFG_W'((7 << 3) | 1));
        count_pulses(100, p);
        check(p == 0, "R7 force code 7", p, 0);
        force_n = 1'b1;
        write_cfg(CFG_W'((3 << 6) | (4'hF << 8)));
        wk_in = 4'hF;
        count_pulses(100, p);
        check(p == 0, "R7 input code 3", p, 0);
        check(stat_cause == 4'h0, "R7 no cause", int'(stat_cause), 0);
        wk_in = '0;
        idle_cycles(5);
    endtask

    task automatic t_inputs(input int code, input int thr);
        int lat; bit seen; int p;
        clear_cause();
        write_cfg(CFG_W'((code << 6) | (4'b0100 << 8)));
        wk_in = 4'b0010;
        count_pulses(thr + 10, p);
        check(p == 0, "R8 disabled input ignored", p, 0);
        wk_in = 4'b0000;
        idle_cycles(4);
        wk_in = 4'b0100;
        measure(thr + 20, lat, seen);
        check(seen && lat == thr + 3, "R8 input latency", lat, thr + 3);
        check(stat_cause == 4'b1000, "R8 input cause", int'(stat_cause), 8);
        wk_in = '0;
        idle_cycles(5);
    endtask

    task automatic t_single_pulse_and_w1c();
        int p;
        clear_cause();
        write_cfg(CFG_W'(6));
        bod_alarm = 1'b1;
        count_pulses(30, p);
        check(p == 1, "R9 one pulse while held", p, 1);
        rtc_alarm = 1'b1;
        count_pulses(10, p);
        check(p == 0, "R9 no repulse while held", p, 0);
        check(stat_cause == 4'b0010, "R10 cause sticky", int'(stat_cause), 2);
        bod_alarm = 1'b0; rtc_alarm = 1'b0;
        idle_cycles(5);
        check(stat_cause == 4'b0010, "R10 cause held after drop", int'(stat_cause), 2);
        @(negedge clk); stat_clr_we = 1'b1; stat_clr_mask = 4'b0001;
        @(negedge clk); stat_clr_we = 1'b0; stat_clr_mask = 4'b0000;
        check(stat_cause == 4'b0010, "R10 clear other bit", int'(stat_cause), 2);
        @(negedge clk); stat_clr_we = 1'b1; stat_clr_mask = 4'b0010;
        @(negedge clk); stat_clr_we = 1'b0; stat_clr_mask = 4'b0000;
        check(stat_cause == 4'b0000, "R10 w1c clears", int'(stat_cause), 0);
        rtc_alarm = 1'b1;
        count_pulses(10, p);
        check(p == 1, "R9 new pulse after drop", p, 1);
        rtc_alarm = 1'b0;
        idle_cycles(5);
    endtask

    initial begin
        t_reset();
        t_force_disabled();
        t_force(0, 1);
        t_force(1, 3);
        t_force(2, 32);
        t_force(3, 512);
        t_force(4, 4096);
        t_force(5, 32768);
        t_alarm(1'b0);
        t_alarm(1'b1);
        t_restart();
        t_reserved();
        t_inputs(0, 1);
        t_inputs(1, 3);
        t_inputs(2, 32);
        t_single_pulse_and_w1c();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule